// File: doc/BRIEF.md
# Pin Event Detector with Grouped Interrupts

This block watches a bank of general-purpose pin inputs and records events on them. Every pin passes through a synchronizer. The block then compares the current sample with the sample from the previous cycle, so it can find rising and falling edges. It also checks the current sample to find high and low levels. Software sets four independent enable masks per pin: rising edge, falling edge, high level and low level. When an enabled condition is true for a pin, that pin's bit in a sticky status word is set. The bit stays set until software writes a 1 to it.

Three interrupt lines summarise the status bits over fixed pin ranges. The middle range crosses the boundary between the two 32-bit status words. An interrupt handler therefore has to look at both words when the middle line is active. The block also holds two more mask pairs for asynchronous edge enables. Software can write and read these masks, but they feed no detector.

The register port is a plain 32-bit access port with no back-pressure. Every write and every read is accepted in the cycle it is presented. Read data is returned one cycle later, marked by a one-cycle valid pulse. The port has no ready signal, so the master must not expect to be stalled.

Top module: `pin_event_top`

## Requirements
- R1: After reset, all enable masks, both status words and all three interrupt outputs are 0.
- R2: Pin p occupies bit p mod 32 of word p/32. Word 0 of a register sits at its base offset and word 1 at base+4. Status words are at 0x40/0x44 and rising-edge enables at 0x4C/0x50. With its rising enable set, a 0-to-1 change on a pin sets its status bit on the third rising clock edge after the change.
- R3: Falling-edge enables are at 0x58/0x5C. With its falling enable set, a 1-to-0 change on a pin sets its status bit.
- R4: With both edge enables set, a pin records an event on either edge.
- R5: High-level enables are at 0x64/0x68. While a pin is high and its high enable is set, its status bit is set. If software clears the bit while the condition lasts, the bit is set again in the next cycle.
- R6: Low-level enables are at 0x70/0x74. While a pin is low and its low enable is set, its status bit is set.
- R7: Writing a status word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: Clearing an enable does not clear a status bit that has already been latched.
- R9: irq_out[0] is the OR of the status bits for pins 0..27. irq_out[1] covers pins 28..45. irq_out[2] covers pins 46..53.
- R10: The asynchronous edge enable words at 0x7C/0x80 and 0x88/0x8C can be written and read back. They do not cause any status bit to be set.
- R11: If a new event and a write-1 clear hit the same status bit in the same cycle, the bit stays set.
- R12: A pin condition whose enable is 0 does not set a status bit.
- R13: bus_rdata is valid, with bus_rvalid high, in the cycle after bus_rd. Word-1 bits above pin 53 (bits 31:22) are ignored on write and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock edge |
| pin_in | input | 54 | Raw pin levels, not synchronized |
| bus_wr | input | 1 | Write strobe, accepted in the cycle it is high |
| bus_rd | input | 1 | Read strobe, accepted in the cycle it is high |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | High for one cycle when bus_rdata holds read data |
| irq_out | output | 3 | Grouped interrupt lines |

## Verification
The properties assume reset is held low for at least one clock edge before the first access. They also assume accesses use word-aligned offsets from the register map, and that bus_wr and bus_rd are never high in the same cycle. Pin inputs may change at any time, so the properties make no assumption about them. The directed stimulus holds reset low for three edges at the start. It drives pins and bus strobes only on falling clock edges, always uses aligned offsets, and never issues a read and a write together.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

  typedef enum logic [2:0] {
    K_STAT  = 3'd0,
    K_RISE  = 3'd1,
    K_FALL  = 3'd2,
    K_HIGH  = 3'd3,
    K_LOW   = 3'd4,
    K_ARISE = 3'd5,
    K_AFALL = 3'd6
  } reg_kind_e;

  localparam int NUM_KINDS = 7;
  localparam int NUM_IRQS  = 3;

  typedef struct packed {
    logic      hit;
    reg_kind_e kind;
    logic [3:0] word;
  } reg_sel_t;

  // Byte offset of word 0 of each register kind; software depends on these.
  function automatic int kind_base(input int k);
    case (k)
      0:       return 'h40;
      1:       return 'h4C;
      2:       return 'h58;
      3:       return 'h64;
      4:       return 'h70;
      5:       return 'h7C;
      default: return 'h88;
    endcase
  endfunction

  function automatic reg_sel_t decode_addr(input logic [15:0] addr, input int nwords);
    reg_sel_t s;
    int diff;
    s = '0;
    for (int k = 0; k < NUM_KINDS; k++) begin
      diff = int'(addr) - kind_base(k);
      if (diff >= 0 && diff < nwords * 4 && (diff & 3) == 0) begin
        s.hit  = 1'b1;
        s.kind = reg_kind_e'(k);
        s.word = 4'(diff / 4);
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/pe_sync.sv
module pe_sync #(
  parameter int WIDTH  = 54,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] prev
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign cur = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '0;
    else        prev <= cur;
  end
endmodule

// File: rtl/pe_qualify.sv
module pe_qualify #(
  parameter int WIDTH = 54
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] prev,
  input  logic [WIDTH-1:0] en_rise,
  input  logic [WIDTH-1:0] en_fall,
  input  logic [WIDTH-1:0] en_high,
  input  logic [WIDTH-1:0] en_low,
  output logic [WIDTH-1:0] ev_vec
);
  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    logic up, down;
    assign up   = cur[p] & ~prev[p];
    assign down = ~cur[p] & prev[p];
    assign ev_vec[p] = (en_rise[p] & up) | (en_fall[p] & down) |
                       (en_high[p] & cur[p]) | (en_low[p] & ~cur[p]);
  end
endmodule

// File: rtl/pe_status.sv
module pe_status #(
  parameter int WIDTH = 54
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] ev_vec,
  input  logic [WIDTH-1:0] clr_mask,
  output logic [WIDTH-1:0] status_q
);
  // A new event wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_mask) | ev_vec;
  end
endmodule

// File: rtl/pe_regs.sv
module pe_regs
  import pin_evt_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  input  logic [NUM_PINS-1:0] status_q,
  output logic [NUM_PINS-1:0] en_rise,
  output logic [NUM_PINS-1:0] en_fall,
  output logic [NUM_PINS-1:0] en_high,
  output logic [NUM_PINS-1:0] en_low,
  output logic [NUM_PINS-1:0] clr_mask,
  output logic [31:0]         bus_rdata,
  output logic                bus_rvalid
);
  localparam int NUM_WORDS = (NUM_PINS + 31) / 32;
  localparam int PAD_W     = NUM_WORDS * 32;

  reg_sel_t sel;
  assign sel = decode_addr(16'(bus_addr), NUM_WORDS);

  function automatic logic [NUM_PINS-1:0] merge_word(
      input logic [NUM_PINS-1:0] old, input logic [3:0] w, input logic [31:0] data);
    logic [PAD_W-1:0] pad;
    pad = PAD_W'(old);
    pad[int'(w)*32 +: 32] = data;
    return pad[NUM_PINS-1:0];
  endfunction

  function automatic logic [31:0] pick_word(
      input logic [NUM_PINS-1:0] v, input logic [3:0] w);
    logic [PAD_W-1:0] pad;
    pad = PAD_W'(v);
    return pad[int'(w)*32 +: 32];
  endfunction

  logic [NUM_PINS-1:0] en_q [1:NUM_KINDS-1];

  for (genvar k = 1; k < NUM_KINDS; k++) begin : g_en
    always_ff @(posedge clk) begin
      if (!rst_n)
        en_q[k] <= '0;
      else if (bus_wr && sel.hit && int'(sel.kind) == k)
        en_q[k] <= merge_word(en_q[k], sel.word, bus_wdata);
    end
  end

  assign en_rise = en_q[int'(K_RISE)];
  assign en_fall = en_q[int'(K_FALL)];
  assign en_high = en_q[int'(K_HIGH)];
  assign en_low  = en_q[int'(K_LOW)];

  always_comb begin
    clr_mask = '0;
    if (bus_wr && sel.hit && sel.kind == K_STAT)
      clr_mask = merge_word('0, sel.word, bus_wdata);
  end

  logic [NUM_PINS-1:0] rd_src;
  always_comb begin
    rd_src = '0;
    if (sel.kind == K_STAT) rd_src = status_q;
    for (int k = 1; k < NUM_KINDS; k++)
      if (int'(sel.kind) == k) rd_src = en_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= sel.hit ? pick_word(rd_src, sel.word) : 32'h0;
    end
  end
endmodule

// File: rtl/pin_event_top.sv
module pin_event_top
  import pin_evt_pkg::*;
#(
  parameter int NUM_PINS    = 54,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 8,
  parameter int GRP1_FIRST  = 28,
  parameter int GRP2_FIRST  = 46
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                bus_rvalid,
  output logic [NUM_IRQS-1:0] irq_out
);
  logic [NUM_PINS-1:0] cur, prev, ev_vec, clr_mask, status_q;
  logic [NUM_PINS-1:0] en_rise, en_fall, en_high, en_low;

  pe_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .cur(cur), .prev(prev));

  pe_qualify #(.WIDTH(NUM_PINS)) u_qual (
    .cur(cur), .prev(prev), .en_rise(en_rise), .en_fall(en_fall),
    .en_high(en_high), .en_low(en_low), .ev_vec(ev_vec));

  pe_status #(.WIDTH(NUM_PINS)) u_stat (
    .clk(clk), .rst_n(rst_n), .ev_vec(ev_vec), .clr_mask(clr_mask),
    .status_q(status_q));

  pe_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status_q(status_q),
    .en_rise(en_rise), .en_fall(en_fall), .en_high(en_high), .en_low(en_low),
    .clr_mask(clr_mask), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid));

  function automatic logic [NUM_PINS-1:0] group_mask(input int g);
    logic [NUM_PINS-1:0] m;
    int lo, hi;
    lo = (g == 0) ? 0 : (g == 1) ? GRP1_FIRST : GRP2_FIRST;
    hi = (g == 0) ? GRP1_FIRST : (g == 1) ? GRP2_FIRST : NUM_PINS;
    m = '0;
    for (int p = 0; p < NUM_PINS; p++)
      if (p >= lo && p < hi) m[p] = 1'b1;
    return m;
  endfunction

  for (genvar g = 0; g < NUM_IRQS; g++) begin : g_irq
    localparam logic [NUM_PINS-1:0] MASK = group_mask(g);
    assign irq_out[g] = |(status_q & MASK);
  end
endmodule

// File: rtl/pin_event_chk.sv
module pin_event_chk
  import pin_evt_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] status_q,
  input logic [NUM_PINS-1:0] ev_vec,
  input logic [NUM_PINS-1:0] clr_mask,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [31:0]         bus_rdata,
  input logic [NUM_IRQS-1:0] irq_out
);
  localparam int NUM_WORDS = (NUM_PINS + 31) / 32;
  localparam int HI_USED   = NUM_PINS - 32 * (NUM_WORDS - 1);
  localparam logic [63:0] HI_UNUSED = ~((64'd1 << HI_USED) - 64'd1);
  localparam logic [ADDR_W-1:0] STAT_HI = ADDR_W'(kind_base(0) + 4 * (NUM_WORDS - 1));

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (status_q == '0));

  p_event_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ev_vec) & ~status_q) == '0));

  p_no_spurious_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(ev_vec)) == '0));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_q) & ~$past(clr_mask) & ~status_q) == '0));

  p_irq_drop_needs_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(irq_out) & ~irq_out) == '0) || $past(bus_wr)));

  p_hi_bits_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == STAT_HI) |=> ((64'(bus_rdata) & HI_UNUSED) == 64'd0));
endmodule

bind pin_event_top pin_event_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .status_q(status_q), .ev_vec(ev_vec),
  .clr_mask(clr_mask), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq_out(irq_out));

// File: tb/sim_pin_event_top.sv
`timescale 1ns/100ps
module sim_pin_event_top;
  localparam int NP = 54;
  localparam logic [7:0] A_ST0 = 8'h40, A_ST1 = 8'h44, A_RI0 = 8'h4C, A_RI1 = 8'h50,
    A_FA0 = 8'h58, A_FA1 = 8'h5C, A_HI0 = 8'h64, A_HI1 = 8'h68, A_LO0 = 8'h70,
    A_LO1 = 8'h74, A_AR0 = 8'h7C, A_AR1 = 8'h80, A_AF0 = 8'h88, A_AF1 = 8'h8C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;
  logic [2:0] irq_out;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pin_event_top u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq_out(irq_out));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d; logic v;
    rd(a, d, v);
    chk(d === exp, req, d, exp);
  endtask

  task automatic pin_to(input int p, input logic val);
    @(negedge clk); pins[p] = val;
    repeat (4) @(negedge clk);
  endtask

  task automatic cleanup();
    logic [7:0] en_addrs [12] = '{A_RI0, A_RI1, A_FA0, A_FA1, A_HI0, A_HI1,
                                  A_LO0, A_LO1, A_AR0, A_AR1, A_AF0, A_AF1};
    foreach (en_addrs[i]) wr(en_addrs[i], 32'h0);
    @(negedge clk); pins = '0;
    repeat (4) @(negedge clk);
    wr(A_ST0, 32'hFFFF_FFFF);
    wr(A_ST1, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [7:0] all [14] = '{A_ST0, A_ST1, A_RI0, A_RI1, A_FA0, A_FA1, A_HI0,
                             A_HI1, A_LO0, A_LO1, A_AR0, A_AR1, A_AF0, A_AF1};
    chk(irq_out === 3'b000, "R1 irq after reset", 32'(irq_out), 0);
    foreach (all[i]) chk_rd(all[i], 32'h0, "R1 register after reset");
  endtask

  task automatic t_rise();
    wr(A_RI0, 32'h1 << 5);
    pin_to(5, 1'b1);
    chk_rd(A_ST0, 32'h20, "R2 rising edge pin 5");
    wr(A_ST0, 32'h20);
    pin_to(5, 1'b0);
    chk_rd(A_ST0, 32'h0, "R12 falling edge without enable");
    wr(A_RI1, 32'h1 << 8);
    pin_to(40, 1'b1);
    chk_rd(A_ST1, 32'h100, "R2 rising edge pin 40 upper word");
    cleanup();
  endtask

  task automatic t_fall();
    pin_to(30, 1'b1);
    chk_rd(A_ST0, 32'h0, "R12 nothing enabled");
    wr(A_FA0, 32'h1 << 30);
    pin_to(30, 1'b0);
    chk_rd(A_ST0, 32'h4000_0000, "R3 falling edge pin 30");
    chk(irq_out === 3'b010, "R9 pin 30 in group 1", 32'(irq_out), 32'h2);
    cleanup();
  endtask

  task automatic t_both();
    wr(A_RI1, 32'h1 << 18);
    wr(A_FA1, 32'h1 << 18);
    pin_to(50, 1'b1);
    chk_rd(A_ST1, 32'h1 << 18, "R4 both, rising");
    chk(irq_out === 3'b100, "R9 pin 50 in group 2", 32'(irq_out), 32'h4);
    wr(A_ST1, 32'h1 << 18);
    chk(irq_out === 3'b000, "R7 irq drops after clear", 32'(irq_out), 0);
    pin_to(50, 1'b0);
    chk_rd(A_ST1, 32'h1 << 18, "R4 both, falling");
    cleanup();
  endtask

  task automatic t_level_high();
    pin_to(10, 1'b1);
    wr(A_HI0, 32'h1 << 10);
    chk_rd(A_ST0, 32'h400, "R5 high level sets");
    wr(A_ST0, 32'h400);
    chk_rd(A_ST0, 32'h400, "R5 persistent high re-sets after clear");
    wr(A_HI0, 32'h0);
    wr(A_ST0, 32'h400);
    chk_rd(A_ST0, 32'h0, "R12 high level with enable off");
    cleanup();
  endtask

  task automatic t_level_low();
    wr(A_LO1, 32'h1 << 15);
    chk_rd(A_ST1, 32'h1 << 15, "R6 low level pin 47");
    chk(irq_out === 3'b100, "R9 pin 47 in group 2", 32'(irq_out), 32'h4);
    pin_to(47, 1'b1);
    wr(A_ST1, 32'h1 << 15);
    chk_rd(A_ST1, 32'h0, "R6 no event once pin high");
    cleanup();
  endtask

  task automatic t_w1c();
    wr(A_RI0, 32'h18);
    @(negedge clk); pins[3] = 1'b1; pins[4] = 1'b1;
    repeat (4) @(negedge clk);
    chk_rd(A_ST0, 32'h18, "R7 two events latched");
    wr(A_ST0, 32'h0);
    chk_rd(A_ST0, 32'h18, "R7 writing zero keeps bits");
    wr(A_ST0, 32'h8);
    chk_rd(A_ST0, 32'h10, "R7 writing one clears only that bit");
    cleanup();
  endtask

  task automatic t_sticky();
    wr(A_RI0, 32'h1 << 20);
    pin_to(20, 1'b1);
    wr(A_RI0, 32'h0);
    chk_rd(A_ST0, 32'h1 << 20, "R8 status kept after enable cleared");
    chk(irq_out === 3'b001, "R8 irq kept after enable cleared", 32'(irq_out), 32'h1);
    cleanup();
  endtask

  task automatic irq_one(input int p, input logic [2:0] exp);
    wr(p < 32 ? A_RI0 : A_RI1, 32'h1 << (p % 32));
    pin_to(p, 1'b1);
    chk(irq_out === exp, $sformatf("R9 group of pin %0d", p), 32'(irq_out), 32'(exp));
    cleanup();
  endtask

  task automatic t_irq_bounds();
    irq_one(0, 3'b001);
    irq_one(27, 3'b001);
    irq_one(28, 3'b010);
    irq_one(45, 3'b010);
    irq_one(46, 3'b100);
    irq_one(53, 3'b100);
  endtask

  task automatic t_async();
    wr(A_AR0, 32'hA5A5_5A5A);
    wr(A_AF1, 32'hFFFF_FFFF);
    chk_rd(A_AR0, 32'hA5A5_5A5A, "R10 async rise word 0 readback");
    chk_rd(A_AF1, 32'h003F_FFFF, "R10 R13 async fall word 1 readback");
    pin_to(1, 1'b1);
    pin_to(1, 1'b0);
    chk_rd(A_ST0, 32'h0, "R10 async enables do not detect");
    cleanup();
  endtask

  task automatic t_collide();
    wr(A_RI0, 32'h3000);
    pin_to(13, 1'b1);
    @(negedge clk); pins[12] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = A_ST0; bus_wdata = 32'h3000;
    @(negedge clk); bus_wr = 1'b0;
    chk_rd(A_ST0, 32'h1000, "R11 event beats clear in same cycle");
    cleanup();
  endtask

  task automatic t_port();
    logic [31:0] d; logic v;
    wr(A_RI1, 32'hFFFF_FFFF);
    rd(A_RI1, d, v);
    chk(v === 1'b1, "R13 rvalid one cycle after read", 32'(v), 1);
    chk(d === 32'h003F_FFFF, "R13 unused upper bits read 0", d, 32'h003F_FFFF);
    @(negedge clk);
    chk(bus_rvalid === 1'b0, "R13 rvalid is a single pulse", 32'(bus_rvalid), 0);
    cleanup();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_level_high();
    t_level_low();
    t_w1c();
    t_sticky();
    t_irq_bounds();
    t_async();
    t_collide();
    t_port();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule